// File: doc/BRIEF.md
# Keyed watchdog timer

This block is a watchdog timer. A 12-bit down-counter runs from a slow counter-domain strobe. When it runs out, the block raises a one-clock reset request. Software reaches it through a plain 32-bit register bus: single-cycle writes, and reads decoded from the address alone. The bus side runs on the system clock. The counter side advances only on cycles where `slow_tick` is high, and that strobe stands for the edges of the low-speed counter clock.

Special values written to the key register control the block:
- One value opens the configuration registers for writing. Any other key write closes them again.
- A second value starts the counter.
- A third value refills the counter, which is how software keeps the system alive.

Configuration writes do not reach the counter at once. Each one is held as pending and takes effect after a fixed number of counter-domain strobes. A status register shows which updates are still pending.

An optional early-warning flag can be raised when the count passes a programmed compare value. This gives software a chance to react before the reset request.

Top module: `keyed_wdt`

## Requirements
- R1: After reset, the block reads as follows: divider code 0, reload value 0xFFF, status 0, early-warning register 0. The counter is stopped, and `rst_req` and `early_irq` are low.
- R2: Writing key 0x5555 (bits 15:0 at offset 0x00) opens the divider, reload and early-warning registers. Any other key write closes them. A write to one of these registers while they are closed leaves its read value unchanged and sets no status bit.
- R3: Key 0xCCCC starts the counter. The write loads the counter from the effective reload value and clears the divider phase. Counting then never stops.
- R4: Divider code c (bits 3:0 at offset 0x04) divides the strobe by 2^(c+2) for c below 6, and by 256 for any code of 6 or more. While running, the counter drops by one on every div-th strobe after a load.
- R5: When the counter steps from 1 to 0, `rst_req` is high for exactly one clock. This happens L·div strobes after a load with reload value L. The counter then holds at 0 and raises no further pulse until a key reloads it.
- R6: Key 0xAAAA refills the counter from the effective reload value and restarts the divider phase. A refill before the count runs out postpones the reset request by a full period.
- R7: An accepted write sets a pending bit in the status register (offset 0x0C): bit 0 for the divider, bit 1 for reload, bit 3 for early-warning. Bit 2 always reads 0. The pending bit clears, and the new value takes effect, on the third strobe after the most recent write to that register. A write made while the bit is pending restarts the count.
- R8: The early-warning flag `early_irq` sets when a decrement brings the counter to the compare value in bits 11:0 at offset 0x14, provided the effective enable bit 15 is 1. It stays set until a write to offset 0x14 with bit 14 = 1. That clear acts even while the registers are closed, and it does not change the stored compare value or enable.
- R9: Read layout:
  - Offset 0x00 reads 0.
  - Offset 0x04 returns the divider code in bits 3:0.
  - Offset 0x08 returns the reload value in bits 11:0.
  - Offset 0x14 returns the enable in bit 15 and the compare value in bits 11:0; bit 14 reads 0.
  - Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_tick | input | 1 | One-cycle strobe marking a counter-domain clock edge |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| rst_req | output | 1 | One-clock reset request when the count runs out |
| early_irq | output | 1 | Sticky early-warning flag |

## Verification
The counter value cannot be read, so the hardest case to reach is the early-warning compare. The flag must rise on exactly the strobe where the counter steps onto the compare value, and the reset request must arrive exactly L·div strobes after the reload. This has to hold across all divider codes, including the codes above 6 that are capped at 256.

The stimulus draws the divider code, reload value, compare value and enable at random for each vector, and lets each new setting take effect through the three-strobe pending window. It then refills the counter and steps the strobe one at a time, comparing both outputs after every strobe with times worked out from the divider formula. Directed sequences cover:
- writes while locked;
- relocking by a stray key;
- restarting a pending update;
- clearing the flag while locked;
- a refill just before expiry.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
   // key values compared against write data bits 15:0
   localparam logic [15:0] KEY_UNLOCK = 16'h5555;
   localparam logic [15:0] KEY_RELOAD = 16'hAAAA;
   localparam logic [15:0] KEY_START  = 16'hCCCC;

   // register byte offsets
   localparam int OFS_KEY = 'h00;
   localparam int OFS_PRE = 'h04;
   localparam int OFS_RLD = 'h08;
   localparam int OFS_STS = 'h0C;
   localparam int OFS_EWC = 'h14;

   // early-warning register bit positions
   localparam int EW_EN_BIT  = 15;
   localparam int EW_CLR_BIT = 14;

   // pending-update slots
   localparam int NSLOT    = 3;
   localparam int SLOT_PRE = 0;
   localparam int SLOT_RLD = 1;
   localparam int SLOT_EWC = 2;
endpackage

// File: rtl/kwd_regs.sv
module kwd_regs
   import kwd_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int CNT_W  = 12,
   parameter int PR_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   input  logic [NSLOT-1:0]  pend,
   output logic [NSLOT-1:0]  wr_slot,
   output logic [PR_W-1:0]   pr_q,
   output logic [CNT_W-1:0]  rl_q,
   output logic [CNT_W-1:0]  cmp_q,
   output logic              ewie_q,
   output logic              key_start,
   output logic              key_reload,
   output logic              irq_clr,
   output logic [31:0]       bus_rdata
);
   localparam logic [ADDR_W-1:0] A_KEY = ADDR_W'(OFS_KEY);
   localparam logic [ADDR_W-1:0] A_PRE = ADDR_W'(OFS_PRE);
   localparam logic [ADDR_W-1:0] A_RLD = ADDR_W'(OFS_RLD);
   localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(OFS_STS);
   localparam logic [ADDR_W-1:0] A_EWC = ADDR_W'(OFS_EWC);

   logic unlocked_q;
   logic key_wr;
   logic [15:0] key_val;

   assign key_wr  = bus_wr && (bus_addr == A_KEY);
   assign key_val = bus_wdata[15:0];

   assign key_start  = key_wr && (key_val == KEY_START);
   assign key_reload = key_wr && (key_val == KEY_RELOAD);
   assign irq_clr    = bus_wr && (bus_addr == A_EWC) && bus_wdata[EW_CLR_BIT];

   assign wr_slot[SLOT_PRE] = bus_wr && unlocked_q && (bus_addr == A_PRE);
   assign wr_slot[SLOT_RLD] = bus_wr && unlocked_q && (bus_addr == A_RLD);
   assign wr_slot[SLOT_EWC] = bus_wr && unlocked_q && (bus_addr == A_EWC);

   // write protection: only the unlock key opens, any other key closes
   always_ff @(posedge clk) begin
      if (!rst_n)      unlocked_q <= 1'b0;
      else if (key_wr) unlocked_q <= (key_val == KEY_UNLOCK);
   end

   // staged configuration, bus side
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pr_q   <= '0;
         rl_q   <= '1;
         cmp_q  <= '0;
         ewie_q <= 1'b0;
      end else begin
         if (wr_slot[SLOT_PRE]) pr_q <= bus_wdata[PR_W-1:0];
         if (wr_slot[SLOT_RLD]) rl_q <= bus_wdata[CNT_W-1:0];
         if (wr_slot[SLOT_EWC]) begin
            cmp_q  <= bus_wdata[CNT_W-1:0];
            ewie_q <= bus_wdata[EW_EN_BIT];
         end
      end
   end

   // read decode
   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         A_PRE: bus_rdata[PR_W-1:0]  = pr_q;
         A_RLD: bus_rdata[CNT_W-1:0] = rl_q;
         A_STS: begin
            bus_rdata[0] = pend[SLOT_PRE];
            bus_rdata[1] = pend[SLOT_RLD];
            bus_rdata[3] = pend[SLOT_EWC];
         end
         A_EWC: begin
            bus_rdata[CNT_W-1:0] = cmp_q;
            bus_rdata[EW_EN_BIT] = ewie_q;
         end
         default: bus_rdata = '0;
      endcase
   end

   logic unused_wdata;
   assign unused_wdata = &{1'b0, bus_wdata[31:16]};

   // R2: a write while closed changes no stored configuration
   a_r2_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !unlocked_q) |=> ($stable(pr_q) && $stable(rl_q) && $stable(cmp_q) && $stable(ewie_q)));
   // R2: any non-unlock key leaves the registers closed
   a_r2_relock: assert property (@(posedge clk) disable iff (!rst_n)
      (key_wr && key_val != KEY_UNLOCK) |=> !unlocked_q);
endmodule

// File: rtl/kwd_sync_slot.sv
module kwd_sync_slot #(
   parameter int SYNC_N = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic start,
   output logic pending,
   output logic apply
);
   localparam int SC_W = $clog2(SYNC_N + 1);
   localparam logic [SC_W-1:0] LAST = SC_W'(SYNC_N - 1);

   logic [SC_W-1:0] sc_q;

   assign apply = pending && tick && !start && (sc_q == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pending <= 1'b0;
         sc_q    <= '0;
      end else if (start) begin
         pending <= 1'b1;
         sc_q    <= '0;
      end else if (pending && tick) begin
         if (sc_q == LAST) begin
            pending <= 1'b0;
            sc_q    <= '0;
         end else begin
            sc_q <= sc_q + 1'b1;
         end
      end
   end

   // R7: a pending flag drops only on a counter-domain strobe
   a_r7_clear_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pending) |-> $past(tick));
   // R7: an accepted write always shows as pending
   a_r7_set_on_write: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> pending);
endmodule

// File: rtl/kwd_core.sv
module kwd_core
   import kwd_pkg::*;
#(
   parameter int CNT_W     = 12,
   parameter int PR_W      = 4,
   parameter int PS_LOG2MN = 2,
   parameter int PS_LOG2MX = 8,
   parameter bit EW_EN     = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             key_start,
   input  logic             key_reload,
   input  logic [NSLOT-1:0] apply,
   input  logic [PR_W-1:0]  pr_q,
   input  logic [CNT_W-1:0] rl_q,
   input  logic [CNT_W-1:0] cmp_q,
   input  logic             ewie_q,
   input  logic             irq_clr,
   output logic             rst_req,
   output logic             early_irq
);
   localparam int SEL_W = $clog2(PS_LOG2MX + 1);
   localparam logic [PR_W-1:0] CODE_CAP = PR_W'(PS_LOG2MX - PS_LOG2MN);

   logic [PR_W-1:0]      pr_eff;
   logic [CNT_W-1:0]     rl_eff, cmp_eff, cnt_q;
   logic                 ewie_eff, running_q;
   logic [PS_LOG2MX-1:0] ps_q, ps_term;
   logic [SEL_W-1:0]     sel;
   logic                 load, dec;

   // effective configuration, counter side
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pr_eff   <= '0;
         rl_eff   <= '1;
         cmp_eff  <= '0;
         ewie_eff <= 1'b0;
      end else begin
         if (apply[SLOT_PRE]) pr_eff <= pr_q;
         if (apply[SLOT_RLD]) rl_eff <= rl_q;
         if (apply[SLOT_EWC]) begin
            cmp_eff  <= cmp_q;
            ewie_eff <= ewie_q;
         end
      end
   end

   // divider ratio select: codes at or above the cap give the largest ratio
   always_comb begin
      if (pr_eff >= CODE_CAP) sel = SEL_W'(PS_LOG2MX);
      else                    sel = SEL_W'(pr_eff) + SEL_W'(PS_LOG2MN);
      for (int i = 0; i < PS_LOG2MX; i++) ps_term[i] = (SEL_W'(i) < sel);
   end

   assign load = key_start || key_reload;
   assign dec  = running_q && tick && (ps_q == ps_term);

   always_ff @(posedge clk) begin
      if (!rst_n)         running_q <= 1'b0;
      else if (key_start) running_q <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                 ps_q <= '0;
      else if (load)              ps_q <= '0;
      else if (running_q && tick) ps_q <= dec ? '0 : ps_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '1;
         rst_req <= 1'b0;
      end else begin
         rst_req <= dec && !load && (cnt_q == CNT_W'(1));
         if (load)                       cnt_q <= rl_eff;
         else if (dec && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
      end
   end

   generate
      if (EW_EN) begin : g_ew
         logic flag_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               flag_q <= 1'b0;
            else if (dec && !load && ewie_eff && cnt_q != '0 && (cnt_q - 1'b1) == cmp_eff)
               flag_q <= 1'b1;
            else if (irq_clr)
               flag_q <= 1'b0;
         end
         assign early_irq = flag_q;

         // R8: the flag can rise only with the warning enabled
         a_r8_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(early_irq) |-> $past(ewie_eff));
      end else begin : g_no_ew
         assign early_irq = 1'b0;
         logic unused_ew;
         assign unused_ew = &{1'b0, cmp_eff, ewie_eff, irq_clr};
      end
   endgenerate

   // R5: the reset request lasts a single clock
   a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req);
   // R5: an expired counter stays at zero until a key reloads it
   a_r5_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == '0 && !load) |=> (cnt_q == '0));
   // R4: without a load the counter moves by exactly one step
   a_r4_step_one: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(cnt_q) && !$past(load)) |-> (cnt_q == $past(cnt_q) - 1'b1));
   // R3: the start key leaves the counter running
   a_r3_start_runs: assert property (@(posedge clk) disable iff (!rst_n)
      key_start |=> running_q);
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
   import kwd_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int CNT_W     = 12,
   parameter int PR_W      = 4,
   parameter int PS_LOG2MN = 2,
   parameter int PS_LOG2MX = 8,
   parameter int SYNC_N    = 3,
   parameter bit EW_EN     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slow_tick,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              rst_req,
   output logic              early_irq
);
   // elaboration checks on the parameter set
   generate
      if (CNT_W < 2 || CNT_W > EW_CLR_BIT)
         $error("CNT_W must lie between 2 and the early-warning clear bit");
      if (ADDR_W < 5 || ADDR_W > 16)
         $error("ADDR_W must reach offset 0x14");
      if (PS_LOG2MN < 1 || PS_LOG2MX <= PS_LOG2MN || PS_LOG2MX > 16)
         $error("divider exponent range is invalid");
      if ((1 << PR_W) <= (PS_LOG2MX - PS_LOG2MN))
         $error("PR_W too narrow to encode the divider cap");
      if (SYNC_N < 1 || SYNC_N > 15)
         $error("SYNC_N out of range");
   endgenerate

   logic [NSLOT-1:0] wr_slot, pend, apply;
   logic [PR_W-1:0]  pr_q;
   logic [CNT_W-1:0] rl_q, cmp_q;
   logic             ewie_q, key_start, key_reload, irq_clr;

   kwd_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .PR_W(PR_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .pend      (pend),
      .wr_slot   (wr_slot),
      .pr_q      (pr_q),
      .rl_q      (rl_q),
      .cmp_q     (cmp_q),
      .ewie_q    (ewie_q),
      .key_start (key_start),
      .key_reload(key_reload),
      .irq_clr   (irq_clr),
      .bus_rdata (bus_rdata)
   );

   generate
      for (genvar s = 0; s < NSLOT; s++) begin : g_slot
         kwd_sync_slot #(.SYNC_N(SYNC_N)) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (slow_tick),
            .start  (wr_slot[s]),
            .pending(pend[s]),
            .apply  (apply[s])
         );
      end
   endgenerate

   kwd_core #(
      .CNT_W(CNT_W), .PR_W(PR_W), .PS_LOG2MN(PS_LOG2MN),
      .PS_LOG2MX(PS_LOG2MX), .EW_EN(EW_EN)
   ) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (slow_tick),
      .key_start (key_start),
      .key_reload(key_reload),
      .apply     (apply),
      .pr_q      (pr_q),
      .rl_q      (rl_q),
      .cmp_q     (cmp_q),
      .ewie_q    (ewie_q),
      .irq_clr   (irq_clr),
      .rst_req   (rst_req),
      .early_irq (early_irq)
   );
endmodule

// File: tb/test_keyed_wdt.sv
`timescale 1ns/1ps
module test_keyed_wdt;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        slow_tick = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        rst_req, early_irq;

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   keyed_wdt i_keyed_wdt (
      .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .rst_req(rst_req), .early_irq(early_irq)
   );

   function automatic int divf(input int code);
      return (code >= 6) ? 256 : (4 << code);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // all tasks start and end just after a falling edge
   task automatic wr(input int a, input logic [31:0] d);
      bus_addr = 8'(a); bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_chk(input string req, input int a, input logic [31:0] exp);
      bus_addr = 8'(a);
      #1;
      chk(req, bus_rdata, exp);
   endtask

   task automatic tick();
      slow_tick = 1'b1;
      @(negedge clk);
      slow_tick = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   initial begin
      #(180000 * 10);
      if (!done) begin
         miscompares++;
         vectors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 / R9: reset state and read layout
      rd_chk("R1 reload reset", 'h08, 32'h0000_0FFF);
      rd_chk("R1 divider reset", 'h04, 32'h0);
      rd_chk("R1 status reset", 'h0C, 32'h0);
      rd_chk("R1 early-warning reset", 'h14, 32'h0);
      rd_chk("R9 key reads zero", 'h00, 32'h0);
      rd_chk("R9 unmapped reads zero", 'h10, 32'h0);
      chk("R1 rst_req low", {31'b0, rst_req}, 32'h0);
      chk("R1 early_irq low", {31'b0, early_irq}, 32'h0);

      // R2: writes while locked, relock by a stray key
      wr('h04, 32'h3);
      rd_chk("R2 locked divider write ignored", 'h04, 32'h0);
      rd_chk("R2 locked write sets no status", 'h0C, 32'h0);
      wr('h00, 32'h5555);
      wr('h00, 32'h1234);
      wr('h08, 32'h5);
      rd_chk("R2 stray key relocks", 'h08, 32'h0000_0FFF);

      // R7 / R9: pending flags and their three-strobe window
      wr('h00, 32'h5555);
      wr('h04, 32'h0);
      wr('h08, 32'h2);
      wr('h14, 32'h0000_8001);
      rd_chk("R9 early-warning readback", 'h14, 32'h0000_8001);
      rd_chk("R9 reload readback", 'h08, 32'h2);
      rd_chk("R7 pending after writes", 'h0C, 32'hB);
      ticks(2);
      rd_chk("R7 still pending after two strobes", 'h0C, 32'hB);
      tick();
      rd_chk("R7 cleared on third strobe", 'h0C, 32'h0);
      wr('h08, 32'h2);
      ticks(2);
      wr('h08, 32'h2);
      ticks(2);
      rd_chk("R7 rewrite restarts window", 'h0C, 32'h2);
      tick();
      rd_chk("R7 restarted window closes", 'h0C, 32'h0);

      // R3 / R4 / R5 / R8: start with reload 2, divide 4, compare 1
      wr('h00, 32'hCCCC);
      for (int t = 1; t <= 8; t++) begin
         tick();
         chk($sformatf("R5 pulse timing t=%0d", t), {31'b0, rst_req}, {31'b0, t == 8});
         chk($sformatf("R8 warning timing t=%0d", t), {31'b0, early_irq}, {31'b0, t >= 4});
      end
      tick();
      chk("R5 pulse is one clock", {31'b0, rst_req}, 32'h0);
      begin
         int seen = 0;
         for (int t = 0; t < 20; t++) begin
            tick();
            seen += int'(rst_req);
         end
         chk("R5 no repeat without reload", 32'(seen), 32'h0);
      end

      // R8: clear works while locked and keeps the stored setting
      wr('h14, 32'h0000_4000);
      chk("R8 clear while locked", {31'b0, early_irq}, 32'h0);
      rd_chk("R8 clear leaves setting", 'h14, 32'h0000_8001);

      // R6: refresh one strobe before expiry
      wr('h00, 32'hAAAA);
      begin
         int seen = 0;
         for (int t = 0; t < 7; t++) begin
            tick();
            seen += int'(rst_req);
         end
         wr('h00, 32'hAAAA);
         for (int t = 1; t <= 8; t++) begin
            tick();
            if (t < 8) seen += int'(rst_req);
            else chk("R6 pulse a full period after refresh", {31'b0, rst_req}, 32'h1);
         end
         chk("R6 no pulse before refreshed expiry", 32'(seen), 32'h0);
      end

      // R4 / R5 / R8: random divider, reload, compare and enable
      for (int v = 0; v < 24; v++) begin
         int code = int'($urandom % 16);
         int l    = 1 + int'($urandom % 4);
         int cmp  = int'($urandom % l);
         int en   = int'($urandom % 2);
         int d    = divf(code);
         wr('h00, 32'h5555);
         wr('h04, 32'(code));
         wr('h08, 32'(l));
         wr('h14, 32'((en << 15) | (1 << 14) | cmp));
         chk("R8 clear before vector", {31'b0, early_irq}, 32'h0);
         ticks(3);
         rd_chk("R7 settled before vector", 'h0C, 32'h0);
         wr('h00, 32'hAAAA);
         for (int t = 1; t <= l * d; t++) begin
            tick();
            chk($sformatf("R4 R5 code=%0d L=%0d t=%0d", code, l, t),
                {31'b0, rst_req}, {31'b0, t == l * d});
            chk($sformatf("R8 code=%0d L=%0d cmp=%0d en=%0d t=%0d", code, l, cmp, en, t),
                {31'b0, early_irq}, {31'b0, (en == 1) && (t >= (l - cmp) * d)});
         end
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule